// File: doc/BRIEF.md
# Capture/Compare Timer Channel with PWM

The block is one channel of a general-purpose timer. A free-running up-counter is shared by four register slots. Each slot has its own external pin. A slot can time-stamp edges on that pin by latching the counter (capture). It can also act on the pin when the counter reaches the slot's value (compare). A count-enable input moves the counter forward, so a prescaler outside the block sets the count rate. Register and counter values are written through simple load strobes.

Each slot also takes a strobe from an external event comparator. The strobe forces a capture into that slot whatever the slot's mode or edge setting, and it raises no interrupt flag. In PWM mode the fourth slot becomes the shared period and the first three slots become duty values, which gives three PWM outputs. Five sticky flags report the overflow, capture and compare-match events. Each flag is cleared by writing one to it.

Top module: `cc_timer_channel`

## Requirements
- R1: On a clock with `cnt_en` high the counter increases by one. With `cnt_en` low it holds its value. `ld_cnt` loads `ld_data` into the counter and has priority over counting and clearing.
- R2: When the counter steps from all-ones to zero, flag bit 4 (`flags[N]`) is set.
- R3: A slot with `slot_is_cap` low is in compare mode and drives its pin (`pin_oe` high). On the clock where `cnt_en` is high and the counter equals the slot register, the pin takes the action given by its two `cmp_act` bits: 00 keep, 01 low, 10 high, 11 toggle.
- R4: Outside PWM mode, a compare match on slot i with `clr_sel[i]` set makes the counter go to zero instead of counting up. With `clr_sel[i]` clear the counter counts on past the match.
- R5: A slot with `slot_is_cap` high releases its pin (`pin_oe` low). It copies the counter into its register on the pin edge selected by its two `cap_edge` bits: 00 none, 01 rising, 10 falling, 11 both.
- R6: A pin change made between two clock edges is captured on the third rising clock edge that follows. The register is still unchanged after the second edge.
- R7: `evt_strobe[i]` copies the counter into slot i's register on the next edge in any mode and with any edge setting, and it sets no flag.
- R8: In PWM mode the counter returns to zero on the clock after it equals the slot-3 register, so the period is (slot 3 value + 1) counts.
- R9: In PWM mode, pins 0 to 2 are driven and pin 3 is released. After the first period, pin i is high exactly while the counter value c satisfies duty_i != 0 and c <= duty_i. A duty of 0 gives a constant low, and a duty at or above the period value gives a constant high.
- R10: `flags[i]` is set by a pin capture or a compare match on slot i. The flags are sticky, and each is cleared by a one on the matching `flag_clr` bit. When a clear and a new event fall on the same cycle, the event wins.
- R11: `ld_slot[i]` loads `ld_data` into slot i's register. The load has priority over a capture on the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Count tick from the external prescaler |
| pwm_mode | input | 1 | Selects PWM operation |
| slot_is_cap | input | 4 | Per slot: 1 capture, 0 compare |
| cap_edge | input | 8 | Two bits per slot: capture edge select |
| cmp_act | input | 8 | Two bits per slot: compare pin action |
| clr_sel | input | 4 | Per slot: a compare match clears the counter |
| ld_slot | input | 4 | Per slot: load the register from `ld_data` |
| ld_cnt | input | 1 | Load the counter from `ld_data` |
| ld_data | input | CNT_W | Load value |
| evt_strobe | input | 4 | Per slot: forced capture, no flag |
| pin_in | input | 4 | Pin input levels (asynchronous) |
| pin_out | output | 4 | Pin output levels |
| pin_oe | output | 4 | Pin output enables |
| flag_clr | input | 5 | Write-one-to-clear for the flags |
| flags | output | 5 | Bits 0-3 slot events, bit 4 overflow |
| cnt_out | output | CNT_W | Counter value |
| reg_out | output | 4*CNT_W | Slot registers, slot i at bits [i*CNT_W +: CNT_W] |

## Verification
The bench builds the channel with `CNT_W = 6` and the default two-stage synchronizer. The narrow counter makes wrap-around and the overflow flag reachable in a few ticks. Each capture test gets its own counter value, so the bench can sweep every slot against every edge setting and both edge directions: 32 cases, each also checked for the two-versus-three clock timing. It also sweeps every slot against every compare action, and every duty value from 0 to 11 against a period value of 9, with the expected counter and PWM pin levels computed cycle by cycle from the period formula.

// File: rtl/ctm_pkg.sv
package ctm_pkg;

    localparam int N_SLOTS     = 4;
    localparam int PERIOD_SLOT = 3;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_sel_e;

    typedef enum logic [1:0] {
        ACT_KEEP   = 2'b00,
        ACT_LOW    = 2'b01,
        ACT_HIGH   = 2'b10,
        ACT_TOGGLE = 2'b11
    } out_act_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_ev_t;

    function automatic logic edge_hit(edge_sel_e sel, edge_ev_t ev);
        case (sel)
            EDGE_RISE: return ev.rise;
            EDGE_FALL: return ev.fall;
            EDGE_BOTH: return ev.rise | ev.fall;
            default:   return 1'b0;
        endcase
    endfunction

    function automatic logic apply_act(out_act_e act, logic cur);
        case (act)
            ACT_LOW:    return 1'b0;
            ACT_HIGH:   return 1'b1;
            ACT_TOGGLE: return ~cur;
            default:    return cur;
        endcase
    endfunction

endpackage

// File: rtl/ctm_counter.sv
module ctm_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             ld,
    input  logic [CNT_W-1:0] ld_val,
    input  logic             clr_req,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap_evt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    assign wrap_evt = en && !ld && !clr_req && (cnt == CNT_MAX);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (ld) begin
            cnt <= ld_val;
        end else if (en) begin
            cnt <= clr_req ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/ctm_edge_sync.sv
module ctm_edge_sync
    import ctm_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     pin,
    output edge_ev_t ev
);
    logic [STAGES:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
        end else begin
            shreg <= {shreg[STAGES-1:0], pin};
        end
    end

    assign ev.rise = shreg[STAGES-1] & ~shreg[STAGES];
    assign ev.fall = ~shreg[STAGES-1] & shreg[STAGES];
endmodule

// File: rtl/ctm_slot.sv
module ctm_slot
    import ctm_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter bit DUTY_SLOT = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt,
    input  logic             cnt_en,
    input  logic             pwm_mode,
    input  logic             is_cap,
    input  edge_sel_e        edge_sel,
    input  out_act_e         act,
    input  edge_ev_t         ev,
    input  logic             evt,
    input  logic             ld,
    input  logic [CNT_W-1:0] ld_val,
    input  logic             period_clr,
    output logic [CNT_W-1:0] reg_q,
    output logic             match_evt,
    output logic             irq_evt,
    output logic             pin_q,
    output logic             oe
);
    logic compare_active;
    logic cap_pin;

    assign compare_active = pwm_mode || !is_cap;
    assign match_evt      = cnt_en && compare_active && (cnt == reg_q);
    assign cap_pin        = !pwm_mode && is_cap && edge_hit(edge_sel, ev);
    assign irq_evt        = cap_pin || match_evt;
    assign oe             = pwm_mode ? DUTY_SLOT : !is_cap;

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_q <= '0;
        end else if (ld) begin
            reg_q <= ld_val;
        end else if (cap_pin || evt) begin
            reg_q <= cnt;
        end
    end

    generate
        if (DUTY_SLOT) begin : g_duty
            always_ff @(posedge clk) begin
                if (rst) begin
                    pin_q <= 1'b0;
                end else if (pwm_mode) begin
                    if (period_clr) begin
                        pin_q <= (reg_q != '0);
                    end else if (match_evt) begin
                        pin_q <= 1'b0;
                    end
                end else if (match_evt) begin
                    pin_q <= apply_act(act, pin_q);
                end
            end
        end else begin : g_period
            always_ff @(posedge clk) begin
                if (rst || pwm_mode) begin
                    pin_q <= 1'b0;
                end else if (match_evt) begin
                    pin_q <= apply_act(act, pin_q);
                end
            end
        end
    endgenerate
endmodule

// File: rtl/ctm_flags.sv
module ctm_flags #(
    parameter int NF = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NF-1:0] set,
    input  logic [NF-1:0] clr,
    output logic [NF-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= (q & ~clr) | set;
        end
    end
endmodule

// File: rtl/cc_timer_channel.sv
module cc_timer_channel
    import ctm_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cnt_en,
    input  logic                     pwm_mode,
    input  logic [N_SLOTS-1:0]       slot_is_cap,
    input  logic [2*N_SLOTS-1:0]     cap_edge,
    input  logic [2*N_SLOTS-1:0]     cmp_act,
    input  logic [N_SLOTS-1:0]       clr_sel,
    input  logic [N_SLOTS-1:0]       ld_slot,
    input  logic                     ld_cnt,
    input  logic [CNT_W-1:0]         ld_data,
    input  logic [N_SLOTS-1:0]       evt_strobe,
    input  logic [N_SLOTS-1:0]       pin_in,
    output logic [N_SLOTS-1:0]       pin_out,
    output logic [N_SLOTS-1:0]       pin_oe,
    input  logic [N_SLOTS:0]         flag_clr,
    output logic [N_SLOTS:0]         flags,
    output logic [CNT_W-1:0]         cnt_out,
    output logic [N_SLOTS*CNT_W-1:0] reg_out
);
    localparam int NF = N_SLOTS + 1;

    logic [CNT_W-1:0]   cnt;
    logic               wrap_evt;
    logic               clr_req;
    logic               period_clr;
    logic [N_SLOTS-1:0] match_evt;
    logic [N_SLOTS-1:0] irq_evt;
    edge_ev_t           pin_ev [N_SLOTS];

    assign period_clr = pwm_mode && match_evt[PERIOD_SLOT];
    assign clr_req    = pwm_mode ? match_evt[PERIOD_SLOT] : |(match_evt & clr_sel);

    ctm_counter #(.CNT_W(CNT_W)) u_counter (
        .clk      (clk),
        .rst      (rst),
        .en       (cnt_en),
        .ld       (ld_cnt),
        .ld_val   (ld_data),
        .clr_req  (clr_req),
        .cnt      (cnt),
        .wrap_evt (wrap_evt)
    );

    for (genvar i = 0; i < N_SLOTS; i++) begin : g_slot
        ctm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk (clk),
            .rst (rst),
            .pin (pin_in[i]),
            .ev  (pin_ev[i])
        );

        ctm_slot #(
            .CNT_W     (CNT_W),
            .DUTY_SLOT (i != PERIOD_SLOT)
        ) u_slot (
            .clk        (clk),
            .rst        (rst),
            .cnt        (cnt),
            .cnt_en     (cnt_en),
            .pwm_mode   (pwm_mode),
            .is_cap     (slot_is_cap[i]),
            .edge_sel   (edge_sel_e'(cap_edge[2*i +: 2])),
            .act        (out_act_e'(cmp_act[2*i +: 2])),
            .ev         (pin_ev[i]),
            .evt        (evt_strobe[i]),
            .ld         (ld_slot[i]),
            .ld_val     (ld_data),
            .period_clr (period_clr),
            .reg_q      (reg_out[i*CNT_W +: CNT_W]),
            .match_evt  (match_evt[i]),
            .irq_evt    (irq_evt[i]),
            .pin_q      (pin_out[i]),
            .oe         (pin_oe[i])
        );
    end

    ctm_flags #(.NF(NF)) u_flags (
        .clk (clk),
        .rst (rst),
        .set ({wrap_evt, irq_evt}),
        .clr (flag_clr),
        .q   (flags)
    );

    assign cnt_out = cnt;
endmodule

// File: rtl/ctm_checker.sv
module ctm_checker #(
    parameter int CNT_W = 16
) (
    input logic               clk,
    input logic               rst,
    input logic               cnt_en,
    input logic               pwm_mode,
    input logic [3:0]         slot_is_cap,
    input logic [3:0]         clr_sel,
    input logic               ld_cnt,
    input logic [4:0]         flag_clr,
    input logic [4:0]         flags,
    input logic [3:0]         pin_oe,
    input logic [CNT_W-1:0]   cnt_out,
    input logic [4*CNT_W-1:0] reg_out
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && !ld_cnt && !pwm_mode && clr_sel == 4'b0) |=> (cnt_out == $past(cnt_out) + 1'b1)); // R1

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!cnt_en && !ld_cnt) |=> $stable(cnt_out)); // R1

    AST_OVF_FLAG: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && !ld_cnt && !pwm_mode && clr_sel == 4'b0 && cnt_out == CNT_MAX) |=> flags[4]); // R2

    AST_PWM_WRAP: assert property (@(posedge clk) disable iff (rst)
        (pwm_mode && cnt_en && !ld_cnt && cnt_out == reg_out[3*CNT_W +: CNT_W]) |=> (cnt_out == '0)); // R8

    AST_CAP_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (!pwm_mode) |-> ((pin_oe & slot_is_cap) == 4'b0)); // R5

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flags[0] && !flag_clr[0]) |=> flags[0]); // R10
endmodule

bind cc_timer_channel ctm_checker #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cnt_en      (cnt_en),
    .pwm_mode    (pwm_mode),
    .slot_is_cap (slot_is_cap),
    .clr_sel     (clr_sel),
    .ld_cnt      (ld_cnt),
    .flag_clr    (flag_clr),
    .flags       (flags),
    .pin_oe      (pin_oe),
    .cnt_out     (cnt_out),
    .reg_out     (reg_out)
);

// File: tb/cc_timer_channel_bench.sv
module cc_timer_channel_bench;
    localparam int W = 6;

    logic         clk = 1'b0;
    logic         rst;
    logic         cnt_en;
    logic         pwm_mode;
    logic [3:0]   slot_is_cap;
    logic [7:0]   cap_edge;
    logic [7:0]   cmp_act;
    logic [3:0]   clr_sel;
    logic [3:0]   ld_slot;
    logic         ld_cnt;
    logic [W-1:0] ld_data;
    logic [3:0]   evt_strobe;
    logic [3:0]   pin_in;
    logic [3:0]   pin_out;
    logic [3:0]   pin_oe;
    logic [4:0]   flag_clr;
    logic [4:0]   flags;
    logic [W-1:0] cnt_out;
    logic [4*W-1:0] reg_out;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    cc_timer_channel #(.CNT_W(W), .SYNC_STAGES(2)) u_cc_timer_channel (
        .clk(clk), .rst(rst), .cnt_en(cnt_en), .pwm_mode(pwm_mode),
        .slot_is_cap(slot_is_cap), .cap_edge(cap_edge), .cmp_act(cmp_act),
        .clr_sel(clr_sel), .ld_slot(ld_slot), .ld_cnt(ld_cnt), .ld_data(ld_data),
        .evt_strobe(evt_strobe), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .flag_clr(flag_clr), .flags(flags), .cnt_out(cnt_out), .reg_out(reg_out)
    );

    task automatic cyc(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int slot_reg(int s);
        return int'(reg_out[s*W +: W]);
    endfunction

    task automatic load_reg(int s, int v);
        ld_slot = 4'(1 << s); ld_data = W'(v); cyc(); ld_slot = '0;
    endtask

    task automatic load_cnt(int v);
        ld_cnt = 1'b1; ld_data = W'(v); cyc(); ld_cnt = 1'b0;
    endtask

    task automatic clear_flags();
        flag_clr = '1; cyc(); flag_clr = '0;
    endtask

    task automatic tick(int n);
        cnt_en = 1'b1; cyc(n); cnt_en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cnt_en = 0; pwm_mode = 0; slot_is_cap = '0; cap_edge = '0;
        cmp_act = '0; clr_sel = '0; ld_slot = '0; ld_cnt = 0; ld_data = '0;
        evt_strobe = '0; pin_in = '0; flag_clr = '0;
        cyc(3);
        rst = 1'b0;
        cyc();

        // reset state
        chk("R1 reset cnt", int'(cnt_out), 0);
        chk("R10 reset flags", int'(flags), 0);
        chk("R11 reset regs", int'(reg_out), 0);
        chk("R3 reset pins", int'(pin_out), 0);

        // R1: counting, holding and loading
        load_cnt(10);
        chk("R1 load", int'(cnt_out), 10);
        tick(3);
        chk("R1 count", int'(cnt_out), 13);
        cyc(4);
        chk("R1 hold", int'(cnt_out), 13);

        // R2: overflow at all-ones
        load_cnt(62);
        tick(1);
        chk("R2 at max", int'(cnt_out), 63);
        chk("R2 no flag yet", int'(flags[4]), 0);
        tick(1);
        chk("R2 wrap", int'(cnt_out), 0);
        chk("R2 flag set", int'(flags[4]), 1);
        flag_clr = 5'b10000; cyc(); flag_clr = '0;
        chk("R10 clear overflow", int'(flags[4]), 0);
        load_cnt(63);
        flag_clr = 5'b10000; tick(1); flag_clr = '0;
        chk("R10 event wins over clear", int'(flags[4]), 1);
        clear_flags();

        // R3: every compare action on every slot
        slot_is_cap = '0;
        for (int s = 0; s < 4; s++) load_reg(s, 20 + s);
        for (int s = 0; s < 4; s++) begin
            for (int a = 0; a < 4; a++) begin
                cmp_act = '0; cmp_act[2*s +: 2] = 2'b01;
                load_cnt(20 + s); tick(1);
                chk("R3 preset low", int'(pin_out[s]), 0);
                clear_flags();
                cmp_act[2*s +: 2] = 2'(a);
                load_cnt(20 + s); tick(1);
                chk("R3 first match", int'(pin_out[s]), (a == 2 || a == 3) ? 1 : 0);
                chk("R10 match flag", int'(flags[s]), 1);
                chk("R3 compare drives", int'(pin_oe[s]), 1);
                load_cnt(20 + s); tick(1);
                chk("R3 second match", int'(pin_out[s]), (a == 2) ? 1 : 0);
            end
        end
        cmp_act = '0;
        clear_flags();
        cyc(2);
        chk("R10 flags stay clear without events", int'(flags), 0);

        // R4: clear on compare match
        clr_sel = 4'b0010;
        load_cnt(19);
        tick(1); chk("R4 before match", int'(cnt_out), 20);
        tick(1); chk("R4 at match", int'(cnt_out), 21);
        tick(1); chk("R4 cleared", int'(cnt_out), 0);
        clr_sel = '0;
        load_cnt(21);
        tick(1); chk("R4 not selected", int'(cnt_out), 22);

        // R5 / R6 / R10: capture sweep over slot, edge select and direction
        slot_is_cap = '1;
        for (int s = 0; s < 4; s++) begin
            for (int sel = 0; sel < 4; sel++) begin
                for (int dir = 0; dir < 2; dir++) begin
                    int v;
                    bit hit;
                    v = 10 + s * 8 + sel * 2 + dir;
                    hit = (sel == 3) || (sel == 1 && dir == 0) || (sel == 2 && dir == 1);
                    cap_edge = '0;
                    pin_in[s] = (dir == 0) ? 1'b0 : 1'b1;
                    cyc(4);
                    load_reg(s, 63);
                    load_cnt(v);
                    clear_flags();
                    cap_edge[2*s +: 2] = 2'(sel);
                    pin_in[s] = ~pin_in[s];
                    cyc(2);
                    chk("R6 not yet captured", slot_reg(s), 63);
                    cyc(1);
                    chk("R5 captured value", slot_reg(s), hit ? v : 63);
                    chk("R10 capture flag", int'(flags[s]), hit ? 1 : 0);
                    chk("R5 capture releases pin", int'(pin_oe[s]), 0);
                end
            end
        end
        cap_edge = '0;
        cyc(4);

        // R7: forced capture in compare mode and with capture off, no flag
        slot_is_cap = 4'b0100;
        load_reg(0, 63); load_reg(2, 63);
        load_cnt(33);
        clear_flags();
        evt_strobe = 4'b0101; cyc(); evt_strobe = '0;
        chk("R7 strobe in compare slot", slot_reg(0), 33);
        chk("R7 strobe with capture off", slot_reg(2), 33);
        chk("R7 no flag", int'(flags[3:0]), 0);

        // R11: load wins over a same-cycle capture
        ld_slot = 4'b0010; ld_data = W'(7); evt_strobe = 4'b0010; cyc();
        ld_slot = '0; evt_strobe = '0;
        chk("R11 load beats capture", slot_reg(1), 7);

        // R8 / R9: PWM sweep, period value 9, duties 0..11
        slot_is_cap = '0;
        clear_flags();
        for (int g = 0; g < 4; g++) begin
            int c;
            pwm_mode = 1'b0;
            for (int i = 0; i < 3; i++) load_reg(i, 3 * g + i);
            load_reg(3, 9);
            load_cnt(0);
            pwm_mode = 1'b1;
            cnt_en = 1'b1;
            cyc(12);
            c = 12 % 10;
            for (int t = 0; t < 25; t++) begin
                chk("R8 pwm counter", int'(cnt_out), c);
                for (int i = 0; i < 3; i++) begin
                    int d;
                    d = 3 * g + i;
                    chk("R9 pwm level", int'(pin_out[i]), (d != 0 && c <= d) ? 1 : 0);
                end
                cyc();
                c = (c == 9) ? 0 : c + 1;
            end
            cnt_en = 1'b0;
            chk("R9 pwm enables", int'(pin_oe), 7);
            chk("R9 period pin low", int'(pin_out[3]), 0);
            chk("R10 period match flag", int'(flags[3]), 1);
        end
        pwm_mode = 1'b0;
        cyc(2);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule